// File: doc/BRIEF.md
# Latched Bidirectional Bus Transceiver

This block moves a byte-wide value between two ports, A and B. Each direction has its own bank of storage that behaves as a level-sensitive latch. Each direction also has three active-low controls: a direction enable, a latch enable and an output enable. Each port has an input bus, an output bus and a drive flag. The drive flag takes the place of a tri-state buffer enable, so a pad wrapper can build an inout net from the three signals.

A direction is open while both its direction enable and its latch enable are low. While open, the far port shows the near input combinationally, and the stored value follows that input at every rising `clk` edge. Raising either of those two enables closes the path. The output then keeps the value that was present at the last clock edge during which the path was open. Output gating is separate from the latch. A port is driven only while its direction enable and its output enable are both low.

An active-high reset clears both stores and silences both ports. After reset, neither port is driven until a clock edge at which both output enables are high.

Top module: `xcvr_latched_top`

## Requirements
- R1: While `ab_en_n` and `ab_le_n` are both low, `b_out` equals `a_in` in the same cycle, including changes made between clock edges.
- R2: When `ab_le_n` rises while `ab_en_n` stays low, `b_out` keeps the `a_in` value sampled at the last rising clock edge at which the path was open.
- R3: When `ab_en_n` rises while `ab_le_n` stays low, `b_out` likewise keeps the value sampled at the last open clock edge.
- R4: While `ab_en_n` or `ab_le_n` is high, `b_out` does not change, whatever `a_in` does.
- R5: Outside reset and the post-reset hold-off, `b_drive` is 1 exactly when `ab_en_n` and `ab_oe_n` are both low. `b_out` shows the latch view whether or not it is driven.
- R6: Output enable and latch are independent. Data captured while `ab_oe_n` is high is shown unchanged once `ab_oe_n` goes low with the latch closed.
- R7: The B-to-A direction behaves the same way: `ba_en_n`, `ba_le_n` and `ba_oe_n` act on `b_in`, `a_out` and `a_drive`.
- R8: While `rst` is 1, `a_drive` and `b_drive` are 0. After a reset edge, both stores read 0 on the output buses while their paths are closed.
- R9: After reset, both drive flags stay 0 until a rising clock edge at which `ab_oe_n` and `ba_oe_n` are both high.
- R10: Each port's drive flag is computed separately, so both ports may be driven in the same cycle, each showing the other port's input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the latch stores |
| rst | input | 1 | Active-high synchronous reset |
| a_in | input | WIDTH | Value arriving at port A |
| a_out | output | WIDTH | Value presented toward port A (B-to-A latch view) |
| a_drive | output | 1 | Port A drive flag |
| b_in | input | WIDTH | Value arriving at port B |
| b_out | output | WIDTH | Value presented toward port B (A-to-B latch view) |
| b_drive | output | 1 | Port B drive flag |
| ab_en_n | input | 1 | A-to-B direction enable, active low |
| ab_le_n | input | 1 | A-to-B latch enable, active low |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_en_n | input | 1 | B-to-A direction enable, active low |
| ba_le_n | input | 1 | B-to-A latch enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |

## Verification
The bench changes the source input between clock edges while a path is open. A design that registers the data instead of passing it through shows the older byte there. It closes each path once by the latch enable and once by the direction enable. A design that captures on only one of them, or lets the view keep following the input, shows the new byte instead of the held one. It also captures with the output gated off and then shows the value later. It releases reset with the output enables still low, where a design without the hold-off drives a port too early. Finally it opens both directions at once, where shared drive logic would silence one port.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // One direction's active-low control set.
  typedef struct packed {
    logic en_n;
    logic le_n;
    logic oe_n;
  } xcvr_ctl_t;

  // The store follows its input only while both enables are low.
  function automatic logic path_open(xcvr_ctl_t c);
    return !c.en_n && !c.le_n;
  endfunction

  // A port is driven when direction and output enables are low and
  // no reset or hold-off silences it.
  function automatic logic path_drive(xcvr_ctl_t c, logic quiet);
    return !quiet && !c.en_n && !c.oe_n;
  endfunction

endpackage

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  xcvr_ctl_t    ctl,
  input  logic         quiet,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_view,
  output logic         drive,
  output logic         open_o,
  output logic         cap_o
);

  logic [W-1:0] store_q;
  logic         open_q;

  assign open_o = path_open(ctl);

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
      open_q  <= 1'b0;
    end else begin
      open_q <= open_o;
      if (open_o) store_q <= d_in;
    end
  end

  // Transparent view while open, stored byte otherwise.
  assign q_view = open_o ? d_in : store_q;
  assign drive  = path_drive(ctl, quiet);
  // Closing event: open at the last edge, closed now.
  assign cap_o  = open_q & ~open_o;

endmodule

// File: rtl/xcvr_guard.sv
module xcvr_guard (
  input  logic clk,
  input  logic rst,
  input  logic oe_x_n,
  input  logic oe_y_n,
  output logic hold_off
);

  always_ff @(posedge clk) begin
    if (rst)                    hold_off <= 1'b1;
    else if (oe_x_n && oe_y_n)  hold_off <= 1'b0;
  end

endmodule

// File: rtl/xcvr_latched_top.sv
module xcvr_latched_top
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_drive,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_drive,
  input  logic             ab_en_n,
  input  logic             ab_le_n,
  input  logic             ab_oe_n,
  input  logic             ba_en_n,
  input  logic             ba_le_n,
  input  logic             ba_oe_n
);

  xcvr_ctl_t ab_ctl, ba_ctl;
  logic      hold_off, quiet;
  logic      ab_open, ab_cap, ba_open, ba_cap;

  assign ab_ctl = '{en_n: ab_en_n, le_n: ab_le_n, oe_n: ab_oe_n};
  assign ba_ctl = '{en_n: ba_en_n, le_n: ba_le_n, oe_n: ba_oe_n};
  assign quiet  = rst | hold_off;

  xcvr_guard guard_i (
    .clk      (clk),
    .rst      (rst),
    .oe_x_n   (ab_oe_n),
    .oe_y_n   (ba_oe_n),
    .hold_off (hold_off)
  );

  xcvr_lane #(.W(WIDTH)) ab_lane_i (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ab_ctl),
    .quiet  (quiet),
    .d_in   (a_in),
    .q_view (b_out),
    .drive  (b_drive),
    .open_o (ab_open),
    .cap_o  (ab_cap)
  );

  xcvr_lane #(.W(WIDTH)) ba_lane_i (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ba_ctl),
    .quiet  (quiet),
    .d_in   (b_in),
    .q_view (a_out),
    .drive  (a_drive),
    .open_o (ba_open),
    .cap_o  (ba_cap)
  );

endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] a_out,
  input logic             a_drive,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] b_out,
  input logic             b_drive,
  input logic             ab_en_n,
  input logic             ab_oe_n,
  input logic             ba_en_n,
  input logic             ba_oe_n,
  input logic             ab_open,
  input logic             ab_cap,
  input logic             ba_open,
  input logic             ba_cap,
  input logic             hold_off
);

  AST_AB_PASS: assert property (@(posedge clk) disable iff (rst)
    ab_open |-> (b_out == a_in)); // R1

  AST_AB_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    ab_cap |-> (b_out == $past(a_in))); // R2

  AST_AB_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ab_open && !$past(ab_open) && !$past(rst)) |-> (b_out == $past(b_out))); // R4

  AST_B_DRIVE: assert property (@(posedge clk) disable iff (rst)
    b_drive |-> (!ab_en_n && !ab_oe_n)); // R5

  AST_BA_PASS: assert property (@(posedge clk) disable iff (rst)
    ba_open |-> (a_out == b_in)); // R7

  AST_BA_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    ba_cap |-> (a_out == $past(b_in))); // R7

  AST_BA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ba_open && !$past(ba_open) && !$past(rst)) |-> (a_out == $past(a_out))); // R7

  AST_A_DRIVE: assert property (@(posedge clk) disable iff (rst)
    a_drive |-> (!ba_en_n && !ba_oe_n)); // R7

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |-> (!a_drive && !b_drive)); // R8

  AST_HOLDOFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    hold_off |-> (!a_drive && !b_drive)); // R9

endmodule

bind xcvr_latched_top xcvr_chk #(.WIDTH(WIDTH)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .a_in     (a_in),
  .a_out    (a_out),
  .a_drive  (a_drive),
  .b_in     (b_in),
  .b_out    (b_out),
  .b_drive  (b_drive),
  .ab_en_n  (ab_en_n),
  .ab_oe_n  (ab_oe_n),
  .ba_en_n  (ba_en_n),
  .ba_oe_n  (ba_oe_n),
  .ab_open  (ab_open),
  .ab_cap   (ab_cap),
  .ba_open  (ba_open),
  .ba_cap   (ba_cap),
  .hold_off (hold_off)
);

// File: tb/xcvr_latched_top_tb_top.sv
`timescale 1ns/100ps
module xcvr_latched_top_tb_top;

  localparam int W = 8;
  // Control triples are {en_n, le_n, oe_n}.
  localparam logic [2:0] OPEN_DRV = 3'b000;
  localparam logic [2:0] OPEN_OFF = 3'b001;
  localparam logic [2:0] LE_HOLD  = 3'b010;
  localparam logic [2:0] LE_OFF   = 3'b011;
  localparam logic [2:0] EN_HOLD  = 3'b100;
  localparam logic [2:0] ALL_HIGH = 3'b111;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [2:0]   ab_c = ALL_HIGH, ba_c = ALL_HIGH;
  logic [W-1:0] a_out, b_out;
  logic         a_drive, b_drive;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  xcvr_latched_top #(.WIDTH(W)) dut_i (
    .clk     (clk),
    .rst     (rst),
    .a_in    (a_in),
    .a_out   (a_out),
    .a_drive (a_drive),
    .b_in    (b_in),
    .b_out   (b_out),
    .b_drive (b_drive),
    .ab_en_n (ab_c[2]),
    .ab_le_n (ab_c[1]),
    .ab_oe_n (ab_c[0]),
    .ba_en_n (ba_c[2]),
    .ba_le_n (ba_c[1]),
    .ba_oe_n (ba_c[0])
  );

  // Reference state, written from the requirements.
  logic [W-1:0] m_ab = '0, m_ba = '0;
  logic         m_hold = 1'b1;

  always @(posedge clk) begin
    if (rst) begin
      m_ab   <= '0;
      m_ba   <= '0;
      m_hold <= 1'b1;
    end else begin
      if (ab_c[2:1] == 2'b00) m_ab <= a_in;
      if (ba_c[2:1] == 2'b00) m_ba <= b_in;
      if (ab_c[0] && ba_c[0]) m_hold <= 1'b0;
    end
  end

  typedef struct {
    logic [W-1:0] a_o;
    logic [W-1:0] b_o;
    logic         a_d;
    logic         b_d;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  event chk_ev;

  task automatic cyc(input logic r, input logic [W-1:0] a, input logic [W-1:0] b,
                     input logic [2:0] abc, input logic [2:0] bac, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; a_in = a; b_in = b; ab_c = abc; ba_c = bac;
    #1;
    e.b_o = (ab_c[2:1] == 2'b00) ? a_in : m_ab;
    e.a_o = (ba_c[2:1] == 2'b00) ? b_in : m_ba;
    e.b_d = !rst && !m_hold && !ab_c[2] && !ab_c[0];
    e.a_d = !rst && !m_hold && !ba_c[2] && !ba_c[0];
    e.tag = tag;
    exp_q.push_back(e);
    -> chk_ev;
  endtask

  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (a_out !== e.a_o || b_out !== e.b_o || a_drive !== e.a_d || b_drive !== e.b_d) begin
          fails++;
          $display("FAIL %s: actual a_out=%h b_out=%h a_drv=%b b_drv=%b expected a_out=%h b_out=%h a_drv=%b b_drv=%b",
                   e.tag, a_out, b_out, a_drive, b_drive, e.a_o, e.b_o, e.a_d, e.b_d);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    cyc(1, 8'h3C, 8'hC3, ALL_HIGH, ALL_HIGH, "R8 reset, closed stores read 0");
    cyc(1, 8'h3C, 8'hC3, OPEN_DRV, OPEN_DRV, "R8 reset silences drives");
    cyc(0, 8'h11, 8'h22, OPEN_DRV, OPEN_DRV, "R9 hold-off keeps ports quiet");
    cyc(0, 8'h11, 8'h22, OPEN_OFF, OPEN_OFF, "R9 both output enables high");
    cyc(0, 8'h5A, 8'h00, OPEN_DRV, ALL_HIGH, "R9 drive after release");
    cyc(0, 8'hC3, 8'h00, OPEN_DRV, ALL_HIGH, "R1 pass-through follows change");
    cyc(0, 8'h99, 8'h00, LE_HOLD,  ALL_HIGH, "R2 capture on latch enable rise");
    cyc(0, 8'h44, 8'h00, LE_HOLD,  ALL_HIGH, "R4 hold with latch enable high");
    cyc(0, 8'h77, 8'h00, OPEN_DRV, ALL_HIGH, "R1 reopen");
    cyc(0, 8'h88, 8'h00, EN_HOLD,  ALL_HIGH, "R3 capture on direction enable rise");
    cyc(0, 8'hEE, 8'h00, EN_HOLD,  ALL_HIGH, "R4 hold with direction enable high");
    cyc(0, 8'h12, 8'h00, OPEN_OFF, ALL_HIGH, "R5 open but undriven");
    cyc(0, 8'h34, 8'h00, LE_OFF,   ALL_HIGH, "R6 capture while undriven");
    cyc(0, 8'h56, 8'h00, LE_HOLD,  ALL_HIGH, "R6 held value displayed");
    cyc(0, 8'h00, 8'hA5, ALL_HIGH, OPEN_DRV, "R7 B-to-A transparent");
    cyc(0, 8'h00, 8'h5A, ALL_HIGH, OPEN_DRV, "R7 B-to-A follows change");
    cyc(0, 8'h00, 8'h0F, ALL_HIGH, LE_HOLD,  "R7 B-to-A latch enable capture");
    cyc(0, 8'h00, 8'hF0, ALL_HIGH, EN_HOLD,  "R7 B-to-A direction enable hold");
    cyc(0, 8'hAB, 8'hCD, OPEN_DRV, OPEN_DRV, "R10 both ports driven");
    cyc(0, 8'hAB, 8'hCD, OPEN_DRV, OPEN_OFF, "R10 only B driven");
    cyc(0, 8'h61, 8'h62, LE_HOLD,  LE_HOLD,  "R10 both hold and drive");
    cyc(1, 8'h61, 8'h62, LE_HOLD,  LE_HOLD,  "R8 reset mid-operation");
    cyc(1, 8'h61, 8'h62, LE_HOLD,  LE_HOLD,  "R8 stores cleared");
    cyc(0, 8'h61, 8'h62, LE_HOLD,  LE_HOLD,  "R9 hold-off after second reset");
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule